// File: doc/BRIEF.md
# Atomic Byte Unsigned-Minimum Unit

This block carries out one atomic read-modify-write on a single byte of a synchronous memory. It takes a 32-bit instruction word and decodes it into an ordering variant and three register numbers: operand, base and destination. It reads the operand byte and the base address from a register-file read interface during the request cycle. It then fetches the addressed byte and compares it, unsigned, with the operand byte. When the operand is strictly smaller, the operand is written back. The byte as first read is returned, zero-extended, on a register write port.

The unit stays busy from acceptance until completion, so nothing can interleave between the load and the store. A stored byte that is already the minimum costs no write cycle. The unit reports ordering, tag-check, undefined-instruction and stack-pointer alignment flags, and it enforces none of them beyond suppressing the access on a fault.

Top module: `amin_byte_unit`

## Requirements
- R1: An instruction is legal only when `feat_en` is 1 and bits [31:24] = 8'h38, bit 21 = 1 and bits [15:10] = 6'b011100. Any other request completes with `undef` = 1 and `done` in the first cycle after acceptance, with no memory read, no memory write and no register write. In that case `acq`, `rel` and `tag_chk` read 0.
- R2: A legal instruction reads the byte at the address and compares it unsigned with the low byte of the operand register (number in bits [20:16]). The operand is written to the same address only when it is strictly smaller. Otherwise no write cycle occurs, and the memory byte ends as the smaller value.
- R3: On `done` the unit writes the originally loaded byte, zero-extended to 32 bits, to the destination register (number in bits [4:0]).
- R4: A destination number of 31 produces no register write.
- R5: `acq` = bit 23 AND destination not 31. `rel` = bit 22. Both are valid while `done` is high.
- R6: A base number (bits [9:5]) other than 31 takes the full 64-bit address from the register file and sets `tag_chk` = 1. Base 31 takes the address from `sp_val` and sets `tag_chk` = 0.
- R7: With base 31 and `sp_val[3:0]` not zero, the unit raises `align_fault` with `done` one cycle after acceptance, performing no memory access and no register write.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while `busy` is high are ignored.
- R9: `done` comes in the third cycle after acceptance when no write is needed and in the fourth when a write occurs. The write occurs exactly two cycles after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Atomic feature enable; 0 makes every request undefined |
| req_valid | input | 1 | Request strobe, taken when not busy |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| rf_base_sel | output | 5 | Register number for the base address read |
| rf_base_data | input | 64 | Base register value |
| rf_src_sel | output | 5 | Register number for the operand read |
| rf_src_data | input | 8 | Low byte of the operand register |
| sp_val | input | 64 | Stack pointer value |
| mem_addr | output | 64 | Memory byte address |
| mem_re | output | 1 | Memory read strobe; data returns one cycle later |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion pulse |
| rf_we | output | 1 | Destination register write enable |
| rf_waddr | output | 5 | Destination register number |
| rf_wdata | output | 32 | Zero-extended loaded byte |
| acq | output | 1 | Acquire ordering flag |
| rel | output | 1 | Release ordering flag |
| tag_chk | output | 1 | Access is tag-checked |
| undef | output | 1 | Instruction undefined |
| align_fault | output | 1 | Stack-pointer alignment fault |

## Verification
The bench uses the default parameters: 8-bit data, 64-bit addresses, 16-byte stack alignment and a 32-bit destination. The memory model indexes by the low address byte. With a byte this narrow, the sweep reaches every stored value from 0 to 255, each paired with 32 operands. The operands include the stored value itself and both of its neighbours, so the equal and off-by-one cases of the unsigned compare are all covered. The sweep also rotates through all four ordering variants and through destinations both 31 and not 31. Directed cases then cover the undefined encodings, aligned and misaligned stack-pointer bases, a base with high address bits set, and requests issued while the unit is busy.

// File: rtl/amin_pkg.sv
package amin_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CMP,
    ST_WRITE,
    ST_DONE
  } amin_state_t;

  typedef struct packed {
    logic       legal;
    logic       acq;
    logic       rel;
    logic       tag;
    logic       use_sp;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rn;
  } amin_dec_t;

  localparam logic [4:0] ZERO_REG = 5'd31;

endpackage

// File: rtl/amin_decode.sv
module amin_decode
  import amin_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        feat_en,
  output amin_dec_t   dec
);
  logic match;

  always_comb begin
    match      = (instr[31:24] == 8'h38) && instr[21] && (instr[15:10] == 6'b011100);
    dec.legal  = feat_en && match;
    dec.rs     = instr[20:16];
    dec.rt     = instr[4:0];
    dec.rn     = instr[9:5];
    dec.acq    = instr[23] && (instr[4:0] != ZERO_REG);
    dec.rel    = instr[22];
    dec.use_sp = (instr[9:5] == ZERO_REG);
    dec.tag    = (instr[9:5] != ZERO_REG);
  end
endmodule

// File: rtl/amin_addr.sv
module amin_addr #(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic              use_sp,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] gpr_val,
  output logic [ADDR_W-1:0] addr,
  output logic              misalign
);
  assign addr = use_sp ? sp_val : gpr_val;

  generate
    if (ALIGN_LOG2 > 0) begin : g_chk
      assign misalign = use_sp && (|sp_val[ALIGN_LOG2-1:0]);
    end else begin : g_nochk
      assign misalign = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/amin_umin.sv
module amin_umin #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] lo,
  output logic              replace
);
  assign replace = operand < stored;
  assign lo      = replace ? operand : stored;
endmodule

// File: rtl/amin_byte_unit.sv
module amin_byte_unit
  import amin_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 64,
  parameter int RF_W       = 32,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              req_valid,
  input  logic [31:0]       instr,
  output logic              busy,
  output logic [4:0]        rf_base_sel,
  input  logic [ADDR_W-1:0] rf_base_data,
  output logic [4:0]        rf_src_sel,
  input  logic [DATA_W-1:0] rf_src_data,
  input  logic [ADDR_W-1:0] sp_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [RF_W-1:0]   rf_wdata,
  output logic              acq,
  output logic              rel,
  output logic              tag_chk,
  output logic              undef,
  output logic              align_fault
);
  localparam int PAD_W = RF_W - DATA_W;

  amin_state_t       state_q, state_d;
  amin_dec_t         dec;
  logic [ADDR_W-1:0] addr_c, addr_q;
  logic              misalign_c;
  logic [DATA_W-1:0] op_q, load_q, min_q, min_c;
  logic              replace_c;
  logic [4:0]        rt_q;
  logic              acq_q, rel_q, tag_q, undef_q, fault_q;
  logic              start, cap_req, cap_load;

  amin_decode i_dec (
    .instr   (instr),
    .feat_en (feat_en),
    .dec     (dec)
  );

  amin_addr #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) i_addr (
    .use_sp   (dec.use_sp),
    .sp_val   (sp_val),
    .gpr_val  (rf_base_data),
    .addr     (addr_c),
    .misalign (misalign_c)
  );

  amin_umin #(.DATA_W(DATA_W)) i_umin (
    .stored  (mem_rdata),
    .operand (op_q),
    .lo      (min_c),
    .replace (replace_c)
  );

  assign rf_base_sel = dec.rn;
  assign rf_src_sel  = dec.rs;
  assign start       = req_valid && (state_q == ST_IDLE);
  assign cap_req     = start;
  assign cap_load    = (state_q == ST_CMP);

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = (!dec.legal || misalign_c) ? ST_DONE : ST_READ;
      ST_READ:  state_d = ST_CMP;
      ST_CMP:   state_d = replace_c ? ST_WRITE : ST_DONE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk) begin
    if (cap_req) begin
      addr_q  <= addr_c;
      op_q    <= rf_src_data;
      rt_q    <= dec.rt;
      acq_q   <= dec.acq && dec.legal;
      rel_q   <= dec.rel && dec.legal;
      tag_q   <= dec.tag && dec.legal;
      undef_q <= !dec.legal;
      fault_q <= dec.legal && misalign_c;
    end
  end

  // loaded byte capture, enabled in the compare state
  always_ff @(posedge clk) begin
    if (cap_load) begin
      load_q <= mem_rdata;
      min_q  <= min_c;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign mem_re      = (state_q == ST_READ);
  assign mem_we      = (state_q == ST_WRITE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = min_q;
  assign done        = (state_q == ST_DONE);
  assign rf_we       = done && !undef_q && !fault_q && (rt_q != ZERO_REG);
  assign rf_waddr    = rt_q;
  assign rf_wdata    = {{PAD_W{1'b0}}, load_q};
  assign acq         = acq_q;
  assign rel         = rel_q;
  assign tag_chk     = tag_q;
  assign undef       = undef_q;
  assign align_fault = fault_q;
endmodule

// File: rtl/amin_checks.sv
module amin_checks #(
  parameter int DATA_W = 8,
  parameter int RF_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_re,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done,
  input logic              rf_we,
  input logic [4:0]        rf_waddr,
  input logic [RF_W-1:0]   rf_wdata,
  input logic              acq,
  input logic              tag_chk,
  input logic              undef,
  input logic              align_fault
);
  p_we_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re, 2));

  p_store_smaller_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata < $past(mem_rdata)));

  p_no_rd_wr_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_zero_extend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_wdata[RF_W-1:DATA_W] == '0));

  p_no_zero_reg_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != 5'd31));

  p_acq_has_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acq && !align_fault && !undef) |-> rf_we);

  p_fault_sp_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && align_fault) |-> (!tag_chk && !rf_we));

  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && undef) |-> (!rf_we && !$past(mem_re)));
endmodule

bind amin_byte_unit amin_checks #(.DATA_W(DATA_W), .RF_W(RF_W)) i_amin_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .mem_re      (mem_re),
  .mem_we      (mem_we),
  .mem_rdata   (mem_rdata),
  .mem_wdata   (mem_wdata),
  .done        (done),
  .rf_we       (rf_we),
  .rf_waddr    (rf_waddr),
  .rf_wdata    (rf_wdata),
  .acq         (acq),
  .tag_chk     (tag_chk),
  .undef       (undef),
  .align_fault (align_fault)
);

// File: tb/test_amin_byte_unit.sv
module test_amin_byte_unit;
  logic        clk, rst_n, feat_en, req_valid;
  logic [31:0] instr;
  logic        busy;
  logic [4:0]  rf_base_sel, rf_src_sel, rf_waddr;
  logic [63:0] rf_base_data, sp_val, mem_addr;
  logic [7:0]  rf_src_data, mem_rdata, mem_wdata;
  logic        mem_re, mem_we, done, rf_we;
  logic [31:0] rf_wdata;
  logic        acq, rel, tag_chk, undef, align_fault;

  logic [63:0] gpr [32];
  logic [7:0]  mem [256];
  int          checks = 0, errors = 0, cycles = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [63:0] last_rd_addr;

  // snapshot taken at done
  int          lat;
  logic        s_rf_we, s_acq, s_rel, s_tag, s_undef, s_fault;
  logic [4:0]  s_waddr;
  logic [31:0] s_wdata;

  amin_byte_unit i_amin_byte_unit (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .req_valid(req_valid), .instr(instr),
    .busy(busy), .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
    .rf_src_sel(rf_src_sel), .rf_src_data(rf_src_data), .sp_val(sp_val),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .done(done), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .acq(acq), .rel(rel), .tag_chk(tag_chk), .undef(undef),
    .align_fault(align_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign rf_base_data = gpr[rf_base_sel];
  assign rf_src_data  = gpr[rf_src_sel][7:0];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_re) begin
      mem_rdata    <= mem[mem_addr[7:0]];
      last_rd_addr <= mem_addr;
      rd_cnt       <= rd_cnt + 1;
    end
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt             <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit a, input bit r, input logic [4:0] rs,
                                     input logic [4:0] rn, input logic [4:0] rt);
    return {8'h38, a, r, 1'b1, rs, 6'b011100, rn, rt};
  endfunction

  task automatic run(input logic [31:0] ins);
    @(negedge clk);
    req_valid = 1'b1;
    instr     = ins;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    s_rf_we = rf_we;   s_waddr = rf_waddr; s_wdata = rf_wdata;
    s_acq   = acq;     s_rel   = rel;      s_tag   = tag_chk;
    s_undef = undef;   s_fault = align_fault;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; feat_en = 1'b1; req_valid = 1'b0; instr = '0; sp_val = '0;
    mem_rdata = '0; last_rd_addr = '0;
    for (int i = 0; i < 32; i++) gpr[i] = 64'h0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we && !rf_we, "R8 reset idle",
        {busy, done, mem_re, mem_we, rf_we}, 0);

    // sweep: all stored values against 32 operands, all variants (R2 R3 R4 R5 R6 R9)
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 32; k++) begin
        logic [7:0] op, idx, emin;
        logic [4:0] rt;
        bit a, r, wr;
        int w0;
        op  = (k < 29) ? 8'(k * 9) : 8'(m + k - 30);
        a   = k[0];
        r   = k[1];
        rt  = (k % 5 == 0) ? 5'd31 : 5'd3;
        idx = 8'(m + k);
        gpr[5] = 64'hFFFF_FFFF_FFFF_FF00 | 64'(op);
        gpr[7] = 64'(idx);
        gpr[3] = 64'hDEAD;
        mem[idx] = 8'(m);
        wr   = (op < 8'(m));
        emin = wr ? op : 8'(m);
        w0   = wr_cnt;
        run(mk(a, r, 5'd5, 5'd7, rt));
        chk(mem[idx] == emin, "R2 stored minimum", mem[idx], emin);
        chk((wr_cnt - w0) == int'(wr), "R2 write only when smaller", wr_cnt - w0, wr);
        chk(lat == (wr ? 4 : 3), "R9 latency", lat, wr ? 4 : 3);
        if (rt != 5'd31)
          chk(s_rf_we && s_waddr == 5'd3 && s_wdata == {24'h0, 8'(m)}, "R3 zero-extended load",
              {s_rf_we, s_waddr, s_wdata}, {1'b1, 5'd3, 24'h0, 8'(m)});
        else
          chk(!s_rf_we, "R4 zero register not written", s_rf_we, 0);
        chk(s_acq == (a && rt != 5'd31) && s_rel == r, "R5 ordering flags",
            {s_acq, s_rel}, {a && rt != 5'd31, r});
        chk(s_tag && !s_undef && !s_fault, "R6 register base tag-checked",
            {s_tag, s_undef, s_fault}, 3'b100);
      end
    end

    // R6: full 64-bit base address from the register file
    begin
      gpr[7] = 64'h8000_0000_0000_0011; gpr[5] = 64'h22; mem[8'h11] = 8'h40;
      run(mk(1'b0, 1'b0, 5'd5, 5'd7, 5'd3));
      chk(last_rd_addr == 64'h8000_0000_0000_0011, "R6 base address", last_rd_addr,
          64'h8000_0000_0000_0011);
      chk(mem[8'h11] == 8'h22, "R2 high address min", mem[8'h11], 8'h22);
    end

    // R1: feature disabled
    begin
      int r0, w0;
      feat_en = 1'b0; mem[8'h20] = 8'h90; gpr[7] = 64'h20; gpr[5] = 64'h01;
      r0 = rd_cnt; w0 = wr_cnt;
      run(mk(1'b1, 1'b1, 5'd5, 5'd7, 5'd3));
      chk(s_undef && lat == 1 && !s_rf_we, "R1 feature off undefined",
          {s_undef, s_rf_we, 8'(lat)}, {1'b1, 1'b0, 8'd1});
      chk(rd_cnt == r0 && wr_cnt == w0 && mem[8'h20] == 8'h90, "R1 feature off no access",
          {rd_cnt - r0, wr_cnt - w0}, 0);
      chk(!s_acq && !s_rel && !s_tag, "R1 undefined flags clear", {s_acq, s_rel, s_tag}, 0);
      feat_en = 1'b1;
      r0 = rd_cnt;
      run(mk(1'b0, 1'b0, 5'd5, 5'd7, 5'd3) ^ 32'h0000_1000);
      chk(s_undef && lat == 1 && rd_cnt == r0, "R1 bad encoding undefined",
          {s_undef, 8'(lat)}, {1'b1, 8'd1});
      r0 = rd_cnt;
      run(mk(1'b0, 1'b0, 5'd5, 5'd7, 5'd3) & ~32'h0020_0000);
      chk(s_undef && rd_cnt == r0, "R1 bit 21 clear undefined", s_undef, 1);
    end

    // R6/R7: stack pointer base
    begin
      int r0;
      gpr[31] = 64'h33; sp_val = 64'h0000_1234_0000_0050;
      mem[8'h50] = 8'h80; mem[8'h33] = 8'h80; gpr[5] = 64'h10;
      run(mk(1'b1, 1'b0, 5'd5, 5'd31, 5'd4));
      chk(last_rd_addr == sp_val && mem[8'h50] == 8'h10 && mem[8'h33] == 8'h80,
          "R6 stack pointer address", last_rd_addr, sp_val);
      chk(!s_tag && !s_fault && s_acq && s_rf_we && s_wdata == 32'h80, "R6 sp not tag-checked",
          {s_tag, s_fault, s_acq, s_wdata}, {3'b001, 32'h80});
      for (int lo = 1; lo < 16; lo += 7) begin
        sp_val = 64'h0000_1234_0000_0050 | 64'(lo);
        r0 = rd_cnt;
        run(mk(1'b0, 1'b1, 5'd5, 5'd31, 5'd4));
        chk(s_fault && lat == 1 && !s_rf_we && rd_cnt == r0, "R7 misaligned sp fault",
            {s_fault, s_rf_we, 8'(lat)}, {1'b1, 1'b0, 8'd1});
      end
    end

    // R8: requests while busy are ignored
    begin
      int r0, n;
      gpr[7] = 64'h60; gpr[8] = 64'h61; gpr[5] = 64'h05;
      mem[8'h60] = 8'h50; mem[8'h61] = 8'h50;
      r0 = rd_cnt;
      @(negedge clk);
      req_valid = 1'b1; instr = mk(1'b0, 1'b0, 5'd5, 5'd7, 5'd3);
      @(negedge clk);
      chk(busy, "R8 busy after accept", busy, 1);
      instr = mk(1'b0, 1'b0, 5'd5, 5'd8, 5'd3);
      n = 0;
      while (!done && n < 20) begin @(negedge clk); n++; end
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(rd_cnt - r0 == 1 && mem[8'h61] == 8'h50 && mem[8'h60] == 8'h05,
          "R8 busy request ignored", {rd_cnt - r0, mem[8'h61]}, {1, 8'h50});
      chk(!busy, "R8 idle after done", busy, 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule